// File: doc/BRIEF.md
# Two-Wire Auto-Incrementing Register Slave

This block is a slave on a two-wire serial bus (I2C-style) that exposes a bank of sixteen 16-bit registers one byte at a time. Both bus lines are sampled by the block's system clock through a synchronizer. Edge detection on the synchronized lines finds START, STOP and the rising and falling clock edges. The data line is driven as an open-drain pull-down enable. A master addresses the block with a fixed 7-bit device address and a direction bit. The block acknowledges and then streams bytes to or from the bank.

There is no register-pointer byte on the bus. An internal 5-bit byte pointer holds the register index in its upper bits and selects the byte in bit 0 (0 = upper byte, 1 = lower byte). A write burst always starts at the upper byte of register 02h and a read burst always starts at the upper byte of register 0Ah. After the lower byte of register 0Fh the pointer wraps to the upper byte of register 00h. Every STOP resets the pointer, and a repeated START restarts address matching.

Top module: `twowire_regslave`

## Requirements
- R1: After reset, and after any STOP (SDA rising while SCL is high), the block does not pull SDA low (`sda_oe_o` = 0, where 1 means pull low).
- R2: The first byte after a START is taken MSB first on rising SCL edges. If its upper seven bits equal 0x10, the block pulls SDA low through the ninth clock, starting after the falling edge that follows the eighth bit. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R3: In a write transfer, each data byte is taken MSB first on rising SCL edges and acknowledged with SDA low on the ninth clock.
- R4: The first written byte of every write transfer goes to the upper byte (bits 15:8) of register 02h, and the next byte goes to its lower byte (bits 7:0).
- R5: A register changes only after its lower byte arrives, and it then takes both bytes together. An upper byte followed by STOP leaves the register unchanged.
- R6: A read transfer starts with the upper byte of register 0Ah. Each bit is driven MSB first after a falling SCL edge, as a pull-down for a 0 bit and a release for a 1 bit.
- R7: In both directions the byte after the lower byte of register 0Fh is the upper byte of register 00h.
- R8: A master acknowledge (SDA low on the ninth clock of a read byte) moves the block on to the next byte. A not-acknowledge makes the block release SDA, and it stays released until the next STOP or START.
- R9: A STOP resets the pointer, so the next write transfer starts again at register 02h.
- R10: A repeated START re-enters address matching, and the start position follows the new direction bit.
- R11: The block starts pulling SDA low only after a falling SCL edge, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull the data line low, 0 = release |

## Verification
The assertions check the following on every cycle:
- the pointer position on entry to the acknowledge of each direction;
- the wrap from the last byte to register 00h;
- the return to idle with the pointer reset after a STOP;
- the release after a master not-acknowledge;
- that no pull-down begins while SCL is high;
- that a lower-byte write always follows a captured upper byte.

Only the bench scenarios can show the actual data. These cover:
- the exact bytes returned by a read burst that crosses the wrap;
- that a rejected address or a lone upper byte leaves the bank untouched;
- that a repeated START to the other direction lands at the other fixed start register.

// File: rtl/twowire_pkg.sv
package twowire_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT,
    ST_WAIT
  } link_state_t;
endpackage

// File: rtl/twowire_line_sync.sv
module twowire_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] prev;

  // idle bus lines are high, so the pipe resets to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
      prev <= '1;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
  assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/twowire_reg_bank.sv
module twowire_reg_bank
  import twowire_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_stb,
  input  logic [BYTE_W-1:0]          wr_byte,
  input  logic [$clog2(NUM_REGS):0]  ptr,
  output logic [BYTE_W-1:0]          rd_byte
);
  localparam int REG_W = 2 * BYTE_W;
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][REG_W-1:0] reg_q;
  logic [BYTE_W-1:0]              hold;
  logic                           hold_vld;
  logic [IDX_W-1:0]               idx;

  assign idx = ptr[IDX_W:1];

  // upper byte is staged until its partner arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      hold_vld <= 1'b0;
    end else if (wr_stb) begin
      if (!ptr[0]) begin
        hold     <= wr_byte;
        hold_vld <= 1'b1;
      end else begin
        hold_vld <= 1'b0;
      end
    end
  end

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr_stb && ptr[0] && idx == IDX_W'(r))
          q <= {hold, wr_byte};
      end
      assign reg_q[r] = q;
    end
  endgenerate

  assign rd_byte = ptr[0] ? reg_q[idx][BYTE_W-1:0] : reg_q[idx][REG_W-1:BYTE_W];

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && ptr[0]) |-> hold_vld); // R5
endmodule

// File: rtl/twowire_link_fsm.sv
module twowire_link_fsm
  import twowire_pkg::*;
#(
  parameter int              NUM_REGS = 16,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h10,
  parameter int              WR_FIRST = 2,
  parameter int              RD_FIRST = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_lvl,
  input  logic                      sda_lvl,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      sda_rise,
  input  logic                      sda_fall,
  input  logic [BYTE_W-1:0]         rd_byte,
  output logic                      wr_stb_o,
  output logic [BYTE_W-1:0]         wr_byte_o,
  output logic [$clog2(NUM_REGS):0] ptr_o,
  output logic                      sda_oe_o
);
  localparam int PTR_W = $clog2(NUM_REGS) + 1;
  localparam logic [PTR_W-1:0] WR_START = PTR_W'(2 * WR_FIRST);
  localparam logic [PTR_W-1:0] RD_START = PTR_W'(2 * RD_FIRST);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(2 * NUM_REGS - 1);

  link_state_t       state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh;
  logic              rw;
  logic [PTR_W-1:0]  ptr;
  logic              sda_oe;

  logic             start_det, stop_det, quiet, byte_done, ptr_inc;
  logic [PTR_W-1:0] ptr_nxt;

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;
  assign quiet     = ~start_det & ~stop_det;
  assign byte_done = (bitcnt == CNT_W'(BYTE_W));
  assign wr_stb_o  = quiet && state == ST_WR && scl_fall && byte_done;
  assign ptr_inc   = wr_stb_o || (quiet && state == ST_RD_ACK && scl_rise && !sda_lvl);
  assign ptr_nxt   = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      ptr    <= WR_START;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      ptr    <= WR_START;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise && !byte_done) begin
            sh     <= {sh[BYTE_W-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && byte_done) begin
            if (state == ST_WR) begin
              sda_oe <= 1'b1;
              ptr    <= ptr_nxt;
              state  <= ST_WR_ACK;
            end else if (sh[BYTE_W-1:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              ptr    <= sh[0] ? RD_START : WR_START;
              state  <= ST_ADDR_ACK;
            end else begin
              state  <= ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
              bitcnt <= CNT_W'(1);
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (byte_done) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              sda_oe <= ~sh[BYTE_W-2];
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (sda_lvl) begin
              state <= ST_WAIT;
            end else begin
              ptr   <= ptr_nxt;
              state <= ST_RD_NEXT;
            end
          end
        end
        ST_RD_NEXT: begin
          if (scl_fall) begin
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[BYTE_W-1];
            bitcnt <= CNT_W'(1);
            state  <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_byte_o = sh;
  assign ptr_o     = ptr;
  assign sda_oe_o  = sda_oe;

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && state == ST_IDLE && ptr == WR_START)); // R9
  AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_oe)); // R10
  AST_WR_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_ACK && !rw) |-> ptr == WR_START); // R4
  AST_RD_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_ACK && rw) |-> ptr == RD_START); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && ptr == PTR_LAST) |=> ptr == '0); // R7
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (quiet && state == ST_RD_ACK && scl_rise && sda_lvl) |=> (state == ST_WAIT && !sda_oe)); // R8
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_lvl)); // R11
endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave
  import twowire_pkg::*;
#(
  parameter int                NUM_REGS    = 16,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h10,
  parameter int                WR_FIRST    = 2,
  parameter int                RD_FIRST    = 10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int PTR_W = $clog2(NUM_REGS) + 1;

  logic [1:0]        line_lvl, line_rise, line_fall;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic [PTR_W-1:0]  ptr;

  twowire_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .lvl (line_lvl),
    .rise(line_rise),
    .fall(line_fall)
  );

  twowire_link_fsm #(
    .NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR),
    .WR_FIRST(WR_FIRST), .RD_FIRST(RD_FIRST)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (line_lvl[1]),
    .sda_lvl  (line_lvl[0]),
    .scl_rise (line_rise[1]),
    .scl_fall (line_fall[1]),
    .sda_rise (line_rise[0]),
    .sda_fall (line_fall[0]),
    .rd_byte  (rd_byte),
    .wr_stb_o (wr_stb),
    .wr_byte_o(wr_byte),
    .ptr_o    (ptr),
    .sda_oe_o (sda_oe_o)
  );

  twowire_reg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .wr_byte(wr_byte),
    .ptr    (ptr),
    .rd_byte(rd_byte)
  );
endmodule

// File: tb/test_twowire_regslave.sv
module test_twowire_regslave;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;

  always #4 clk = ~clk;

  assign sda_line = ~(m_low | sda_oe);

  twowire_regslave i_twowire_regslave (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (m_scl),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] model [16];
  logic [7:0]  hold_m;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic [7:0]  rx_byte;
  event        rx_ev;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wclk(H/2); m_low = ~b;
    wclk(H/2); m_scl = 1'b1;
    wclk(H);   m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wclk(H/2); m_low = 1'b0;
    wclk(H/2); m_scl = 1'b1;
    wclk(H/2); b = sda_line;
    wclk(H/2); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    wclk(H/2); m_low = 1'b0;
    wclk(H/2); m_scl = 1'b1;
    wclk(H/2); m_low = 1'b1;
    wclk(H/2); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(H/2); m_low = 1'b1;
    wclk(H/2); m_scl = 1'b1;
    wclk(H/2); m_low = 1'b0;
    wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack);
  endtask

  task automatic recv_byte(input logic nack, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    logic       b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(nack);
    rx_byte = v;
    -> rx_ev;
  endtask

  task automatic send_addr(input logic [7:0] a, input logic exp_ack, input string tag);
    logic ack;
    send_byte(a, ack);
    check(ack == exp_ack, tag, "address acknowledge", ack, exp_ack);
  endtask

  // sends bytes right after a write address; pointer starts at 02h upper
  task automatic wr_bytes(input logic [7:0] data [$], input string tag);
    int   pos = 4;
    logic ack;
    foreach (data[i]) begin
      send_byte(data[i], ack);
      check(ack == 1'b0, tag, "write data acknowledge", ack, 0);
      if (pos % 2 == 0) hold_m = data[i];
      else model[pos/2] = {hold_m, data[i]};
      pos = (pos + 1) % 32;
    end
  endtask

  // reads n bytes right after a read address; pointer starts at 0Ah upper
  task automatic rd_bytes(input int n, input string tag);
    int pos = 20;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = (pos % 2 == 0) ? model[pos/2][15:8] : model[pos/2][7:0];
      recv_byte(i == n - 1, e, tag);
      pos = (pos + 1) % 32;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected read byte", rx_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rx_byte == e, t, "read byte", rx_byte, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [$];
    logic       ack;
    for (int r = 0; r < 16; r++) model[r] = 16'h0000;
    hold_m = 8'h00;
    wclk(5);
    rst = 1'b0;
    wclk(5);
    check(sda_oe == 1'b0 && sda_line == 1'b1, "R1", "reset leaves SDA released", sda_oe, 0);

    // R2: foreign address, not acknowledged, following byte ignored
    bus_start();
    send_addr(8'h42, 1'b1, "R2");
    send_byte(8'hAA, ack);
    check(ack == 1'b1, "R2", "byte after foreign address", ack, 1);
    bus_stop();
    check(sda_oe == 1'b0, "R1", "SDA released after STOP", sda_oe, 0);

    // R3 R4: short write to 02h/03h
    bus_start();
    send_addr(8'h20, 1'b0, "R2");
    d = '{8'h12, 8'h34, 8'h56, 8'h78};
    wr_bytes(d, "R3");
    bus_stop();

    // R7 R9: full circle write starting at 02h again, wrapping to 00h/01h
    bus_start();
    send_addr(8'h20, 1'b0, "R9");
    d = '{};
    for (int k = 0; k < 32; k++) d.push_back(8'(k * 37 + 5));
    wr_bytes(d, "R7");
    bus_stop();

    // R5: lone upper byte then STOP, register 02h keeps its value
    bus_start();
    send_addr(8'h20, 1'b0, "R5");
    send_byte(8'hEE, ack);
    check(ack == 1'b0, "R5", "lone upper byte acknowledge", ack, 0);
    bus_stop();

    // R2: foreign write address with data, bank must stay untouched
    bus_start();
    send_addr(8'h22, 1'b1, "R2");
    send_byte(8'h99, ack);
    send_byte(8'h88, ack);
    bus_stop();

    // R6 R7 R5: read all 32 bytes from 0Ah, wrapping; NACK on the last one
    bus_start();
    send_addr(8'h21, 1'b0, "R6");
    rd_bytes(32, "R7");
    // R8: after NACK the block must leave SDA released
    recv_byte(1'b1, 8'hFF, "R8");
    bus_stop();

    // R10: repeated START switches direction and start position
    bus_start();
    send_addr(8'h20, 1'b0, "R10");
    d = '{8'hC0, 8'hDE};
    wr_bytes(d, "R10");
    bus_start();
    send_addr(8'h21, 1'b0, "R10");
    rd_bytes(2, "R10");
    bus_start();
    send_addr(8'h20, 1'b0, "R10");
    d = '{8'hBE, 8'hEF};
    wr_bytes(d, "R10");
    bus_stop();

    // R9 R4: read back through the wrap up to register 02h
    bus_start();
    send_addr(8'h21, 1'b0, "R9");
    rd_bytes(18, "R4");
    bus_stop();

    wclk(20);
    check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    check(model[2] == 16'hBEEF, "R4", "bench model of register 02h", model[2], 16'hBEEF);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule